// File: doc/BRIEF.md
# Serial Converter Frame and Power-Mode Sequencer

This block is the digital control half of a 12-bit successive-approximation converter that a host drives over three wires: a convert-start strobe, a serial clock and a three-state data line. A parallel result bus stands in for the analog core. The block decides when the track/hold holds and when it resumes tracking. It captures the core result at the start of a conversion and shifts it out as a 16-clock frame padded with zeros. It also drives the output enable of the data line.

The same two wires select the power state. The state depends on where in a frame the host raises the convert-start strobe. A late rise keeps conversions running back to back. A rise in the middle of the frame moves one step deeper into sleep: first partial power-down, then full power-down. Holding the strobe low through a whole frame wakes the block again. After reset, the first complete frame is a calibration run and its data is flagged as not valid. A parameter selects between straight binary and two's complement coding.

All inputs are sampled on the block clock `clk`. Strobe and serial-clock edges are detected by comparing each input with its registered copy, and every output changes on the clock edge that sees the input edge.

Top module: `adc_serial_seq`

## Requirements
- R1: On a falling edge of `cnvstIn`, in the next cycle `trackMode` is 0 (hold), `doutEnable` is 1 and `doutData` is 0. In normal mode `sampleTaken` also pulses for that one cycle.
- R2: After the n-th rising edge of `sclkIn` in a frame, `doutData` is 0 for n = 1 to 3. For n = 4 to 15 it carries result bits 11 down to 0, most significant first. For n = 16 it is 0.
- R3: `trackMode` is 1 out of reset. It stays 0 through the 13th rising edge of a frame and returns to 1 on the 14th.
- R4: If `cnvstIn` rises after the 14th or 15th rising edge, `doutEnable` stays 1 through the rest of the frame and after it, so the next conversion can follow at once.
- R5: If `cnvstIn` is still low at the 16th falling edge of `sclkIn`, `doutEnable` stays 1 until the next `sclkIn` rising edge, then drops to 0.
- R6: In the case of R5, a rise of `cnvstIn` before any further `sclkIn` rising edge also drops `doutEnable` to 0.
- R7: If `cnvstIn` rises after the 3rd through the 13th rising edge while `powerMode` is 0 (normal), `powerMode` becomes 1 (partial power-down). In the same cycle `doutEnable` goes to 0 and `trackMode` to 1.
- R8: The same early rise while `powerMode` is 1 gives `powerMode` 2 (full power-down). In a frame started while `powerMode` is 1 or 2, every data bit reads 0.
- R9: In power-down, a frame in which `cnvstIn` stays low for at least 14 rising edges before it rises returns `powerMode` to 0. An early rise in full power-down keeps `powerMode` at 2.
- R10: `resultValid` is 0 for a frame started before any frame has completed 16 rising edges since reset, and for frames started in power-down. It is 1 for later normal-mode frames, and waking does not call for a new calibration frame.
- R11: With `BIPOLAR` = 0 the data bits equal `coreResult`. With `BIPOLAR` = 1 the core's offset-binary code is sent as two's complement: the top bit is inverted and the other bits pass unchanged.
- R12: A rise of `cnvstIn` before the 3rd rising edge aborts the frame. `doutEnable` goes to 0, `trackMode` goes to 1 and `powerMode` does not change.
- R13: Out of reset, `doutEnable` = 0, `trackMode` = 1, `powerMode` = 0, `resultValid` = 0 and `sampleTaken` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cnvstIn | input | 1 | Convert-start strobe, idle high |
| sclkIn | input | 1 | Serial clock from the host |
| coreResult | input | DATA_W | Parallel result from the converter core, offset binary |
| sampleTaken | output | 1 | One-cycle pulse when a result is captured |
| trackMode | output | 1 | 1 = track/hold tracking, 0 = holding |
| doutData | output | 1 | Serial data bit |
| doutEnable | output | 1 | Drive enable for the three-state data pin |
| powerMode | output | 2 | 0 normal, 1 partial power-down, 2 full power-down |
| resultValid | output | 1 | The current frame carries a valid result |

## Verification
The bench builds two copies of the block from the same stimulus: one with `BIPOLAR` at 0 and one with `BIPOLAR` at 1. This lets every result vector be compared against both codings in the same frame. Both copies keep the default 12-bit result in a 16-clock frame, so the frame walks through every decision edge that matters. Those edges are the 3rd (power-down window opens), the 13th and 14th (tracking resumes, continuous window opens) and the 16th (linger and release of the data line).

// File: rtl/adc_serial_pkg.sv
package adc_serial_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_FULL    = 2'd2
  } pmode_t;

  typedef struct packed {
    logic load;    // capture a new frame word, drive the line low
    logic blank;   // load zeros instead of the result
    logic shift;   // present the next frame bit
    logic drvOff;  // release the data line
  } ctrlStrobe_t;

endpackage

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_serial_pkg::*;
#(
  parameter int FRAME_LEN     = 16,
  parameter int TRACK_EDGE    = 14,
  parameter int PD_FIRST_EDGE = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cnvstIn,
  input  logic        sclkIn,
  input  logic        doutEnable,
  output ctrlStrobe_t strobe,
  output logic        trackMode,
  output logic        sampleTaken,
  output logic        resultValid,
  output pmode_t      powerMode
);

  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] EDGE_LAST  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] EDGE_TRACK = CNT_W'(TRACK_EDGE);
  localparam logic [CNT_W-1:0] EDGE_PD    = CNT_W'(PD_FIRST_EDGE);

  logic cnvstQ, sclkQ;
  logic cnvFall, cnvRise, sclkRise, sclkFall;
  logic [CNT_W-1:0] edgeCnt, edgeCntNext;
  logic inFrame, lingering, parkPending, calibrated;
  logic earlyRise;

  always_comb begin
    cnvFall     = cnvstQ & ~cnvstIn;
    cnvRise     = ~cnvstQ & cnvstIn;
    sclkRise    = ~sclkQ & sclkIn;
    sclkFall    = sclkQ & ~sclkIn;
    edgeCntNext = edgeCnt + 1'b1;
    earlyRise   = cnvRise && inFrame && (edgeCnt < EDGE_TRACK);
    strobe.load   = cnvFall;
    strobe.blank  = (powerMode != PM_NORMAL);
    strobe.shift  = sclkRise && inFrame;
    strobe.drvOff = earlyRise || (cnvRise && lingering) || (sclkRise && parkPending);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnvstQ      <= 1'b1;
      sclkQ       <= 1'b0;
      edgeCnt     <= '0;
      inFrame     <= 1'b0;
      lingering   <= 1'b0;
      parkPending <= 1'b0;
      calibrated  <= 1'b0;
      trackMode   <= 1'b1;
      sampleTaken <= 1'b0;
      resultValid <= 1'b0;
      powerMode   <= PM_NORMAL;
    end else begin
      cnvstQ      <= cnvstIn;
      sclkQ       <= sclkIn;
      sampleTaken <= cnvFall && (powerMode == PM_NORMAL);
      if (cnvFall) begin
        edgeCnt     <= '0;
        inFrame     <= 1'b1;
        lingering   <= 1'b0;
        parkPending <= 1'b0;
        trackMode   <= 1'b0;
        resultValid <= calibrated && (powerMode == PM_NORMAL);
      end else begin
        if (strobe.shift) begin
          edgeCnt <= edgeCntNext;
          if (edgeCntNext == EDGE_TRACK) trackMode <= 1'b1;
          if (edgeCntNext == EDGE_LAST) begin
            inFrame    <= 1'b0;
            calibrated <= 1'b1;
            lingering  <= ~cnvstIn;
          end
        end
        if (sclkFall && lingering) parkPending <= 1'b1;
        if (sclkRise && parkPending) begin
          parkPending <= 1'b0;
          lingering   <= 1'b0;
        end
        if (cnvRise) begin
          if (lingering) begin
            lingering   <= 1'b0;
            parkPending <= 1'b0;
          end
          if (earlyRise) begin
            inFrame   <= 1'b0;
            trackMode <= 1'b1;
            if (edgeCnt >= EDGE_PD)
              powerMode <= (powerMode == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
          end else if (edgeCnt >= EDGE_TRACK && powerMode != PM_NORMAL) begin
            powerMode <= PM_NORMAL;
          end
        end
      end
    end
  end

  // R3: tracking resumes on the designated rising edge
  a_r3_track_resume: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shift && edgeCntNext == EDGE_TRACK) |=> trackMode);

  // R7: a mid-frame rise releases the data line
  a_r7_pd_release: assert property (@(posedge clk) disable iff (!rstN)
    (cnvRise && inFrame && edgeCnt >= EDGE_PD && edgeCnt < EDGE_TRACK) |=> !doutEnable);

  // R4: a late rise keeps the data line driven
  a_r4_cont_drive: assert property (@(posedge clk) disable iff (!rstN)
    (cnvRise && inFrame && edgeCnt >= EDGE_TRACK) |=> doutEnable);

  // R8: only the three defined power states occur
  a_r8_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    powerMode inside {PM_NORMAL, PM_PARTIAL, PM_FULL});

  // R10: calibration, once done, stays done until reset
  a_r10_cal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    calibrated |=> calibrated);

endmodule

// File: rtl/adc_serial_dpath.sv
module adc_serial_dpath
  import adc_serial_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int FRAME_LEN  = 16,
  parameter bit BIPOLAR    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] coreResult,
  output logic              doutData,
  output logic              doutEnable
);

  localparam int TRAIL_BITS = FRAME_LEN - LEAD_ZEROS - DATA_W;

  logic [DATA_W-1:0]    coded;
  logic [FRAME_LEN-1:0] frameReg, loadWord;

  generate
    if (BIPOLAR) begin : g_bipolar
      assign coded = {~coreResult[DATA_W-1], coreResult[DATA_W-2:0]};
    end else begin : g_unipolar
      assign coded = coreResult;
    end
  endgenerate

  assign loadWord = strobe.blank ? '0
                                 : {{LEAD_ZEROS{1'b0}}, coded, {TRAIL_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg   <= '0;
      doutData   <= 1'b0;
      doutEnable <= 1'b0;
    end else if (strobe.load) begin
      frameReg   <= loadWord;
      doutData   <= 1'b0;
      doutEnable <= 1'b1;
    end else begin
      if (strobe.shift) begin
        doutData <= frameReg[FRAME_LEN-1];
        frameReg <= {frameReg[FRAME_LEN-2:0], 1'b0};
      end
      if (strobe.drvOff) doutEnable <= 1'b0;
    end
  end

  // R1: a conversion start drives the line low
  a_r1_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (doutEnable && !doutData));

  // R8: a blanked frame holds no set bit
  a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.blank) |=> (frameReg == '0));

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_serial_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int LEAD_ZEROS    = 3,
  parameter int FRAME_LEN     = 16,
  parameter int TRACK_EDGE    = 14,
  parameter int PD_FIRST_EDGE = 3,
  parameter bit BIPOLAR       = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvstIn,
  input  logic              sclkIn,
  input  logic [DATA_W-1:0] coreResult,
  output logic              sampleTaken,
  output logic              trackMode,
  output logic              doutData,
  output logic              doutEnable,
  output logic [1:0]        powerMode,
  output logic              resultValid
);

  ctrlStrobe_t strobe;
  pmode_t      pmode;

  adc_serial_ctrl #(
    .FRAME_LEN(FRAME_LEN), .TRACK_EDGE(TRACK_EDGE), .PD_FIRST_EDGE(PD_FIRST_EDGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cnvstIn(cnvstIn), .sclkIn(sclkIn),
    .doutEnable(doutEnable), .strobe(strobe), .trackMode(trackMode),
    .sampleTaken(sampleTaken), .resultValid(resultValid), .powerMode(pmode)
  );

  adc_serial_dpath #(
    .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN), .BIPOLAR(BIPOLAR)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .coreResult(coreResult),
    .doutData(doutData), .doutEnable(doutEnable)
  );

  assign powerMode = pmode;

endmodule

// File: tb/adc_serial_seq_bench.sv
module adc_serial_seq_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cnvst = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] coreResult = '0;
  logic smp, trk, dout, den, val;
  logic [1:0] pm;
  logic smpB, trkB, doutB, denB, valB;
  logic [1:0] pmB;

  int checks = 0;
  int errors = 0;
  logic fallDen, fallDout, fallTrk, fallSmp, fallVal, trk13, trk14;
  logic [15:0] wU, wB;

  always #5 clk = ~clk;

  adc_serial_seq u_adc_serial_seq (
    .clk(clk), .rstN(rstN), .cnvstIn(cnvst), .sclkIn(sclk), .coreResult(coreResult),
    .sampleTaken(smp), .trackMode(trk), .doutData(dout), .doutEnable(den),
    .powerMode(pm), .resultValid(val));

  adc_serial_seq #(.BIPOLAR(1'b1)) u_adc_serial_seq_bip (
    .clk(clk), .rstN(rstN), .cnvstIn(cnvst), .sclkIn(sclk), .coreResult(coreResult),
    .sampleTaken(smpB), .trackMode(trkB), .doutData(doutB), .doutEnable(denB),
    .powerMode(pmB), .resultValid(valB));

  // code, expected unipolar, expected bipolar
  localparam logic [35:0] VECS [6] = '{
    {12'h000, 12'h000, 12'h800},
    {12'hFFF, 12'hFFF, 12'h7FF},
    {12'h800, 12'h800, 12'h000},
    {12'h7FF, 12'h7FF, 12'hFFF},
    {12'hA5C, 12'hA5C, 12'h25C},
    {12'h123, 12'h123, 12'h923}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // riseAt: rising-edge count after which cnvst rises (0 = stays low)
  task automatic runFrame(input int riseAt);
    wU = '0; wB = '0;
    cnvst = 1'b0;
    @(negedge clk);
    fallDen = den; fallDout = dout; fallTrk = trk; fallSmp = smp; fallVal = val;
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b1;
      @(negedge clk);
      wU[16-k] = dout;
      wB[16-k] = doutB;
      if (k == 13) trk13 = trk;
      if (k == 14) trk14 = trk;
      sclk = 1'b0;
      @(negedge clk);
      if (k == riseAt) begin
        cnvst = 1'b1;
        @(negedge clk);
        if (riseAt < 14) return;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R13 den", 32'(den), 0);
    chk("R13 trk", 32'(trk), 1);
    chk("R13 pm", 32'(pm), 0);
    chk("R13 val", 32'(val), 0);
    chk("R13 smp", 32'(smp), 0);

    // calibration frame, continuous
    coreResult = 12'h5A3;
    runFrame(15);
    chk("R1 den", 32'(fallDen), 1);
    chk("R1 dout", 32'(fallDout), 0);
    chk("R1 trk", 32'(fallTrk), 0);
    chk("R1 smp", 32'(fallSmp), 1);
    chk("R10 cal frame invalid", 32'(fallVal), 0);
    chk("R2 frame", 32'(wU), 32'({3'b0, 12'h5A3, 1'b0}));
    chk("R4 stays driven", 32'(den), 1);

    // vector table
    for (int i = 0; i < 6; i++) begin
      coreResult = VECS[i][35:24];
      runFrame(15);
      chk("R11 unipolar", 32'(wU), 32'({3'b0, VECS[i][23:12], 1'b0}));
      chk("R11 bipolar", 32'(wB), 32'({3'b0, VECS[i][11:0], 1'b0}));
      chk("R10 valid", 32'(fallVal), 1);
      chk("R3 hold at 13", 32'(trk13), 0);
      chk("R3 track at 14", 32'(trk14), 1);
      chk("R4 driven", 32'(den), 1);
    end

    // linger released by sclk
    runFrame(0);
    chk("R5 driven after 16th fall", 32'(den), 1);
    sclk = 1'b1; @(negedge clk);
    chk("R5 released by sclk", 32'(den), 0);
    sclk = 1'b0; @(negedge clk);
    cnvst = 1'b1; @(negedge clk);

    // linger released by cnvst
    runFrame(0);
    cnvst = 1'b1; @(negedge clk);
    chk("R6 released by cnvst", 32'(den), 0);

    // early abort
    runFrame(2);
    chk("R12 den", 32'(den), 0);
    chk("R12 pm", 32'(pm), 0);
    chk("R12 trk", 32'(trk), 1);

    // partial then full power-down
    coreResult = 12'hFFF;
    runFrame(6);
    chk("R7 den", 32'(den), 0);
    chk("R7 pm", 32'(pm), 1);
    chk("R7 trk", 32'(trk), 1);
    runFrame(9);
    chk("R8 zero bits", 32'(wU), 0);
    chk("R8 pm full", 32'(pm), 2);
    runFrame(13);
    chk("R9 short low stays full", 32'(pm), 2);
    runFrame(15);
    chk("R8 wake frame zeros", 32'(wU), 0);
    chk("R10 pd frame invalid", 32'(fallVal), 0);
    chk("R9 woke", 32'(pm), 0);

    coreResult = 12'h3C7;
    runFrame(15);
    chk("R10 valid after wake", 32'(fallVal), 1);
    chk("R2 data after wake", 32'(wU), 32'({3'b0, 12'h3C7, 1'b0}));

    // partial then wake at 14th edge
    runFrame(5);
    chk("R7 partial again", 32'(pm), 1);
    runFrame(14);
    chk("R9 wake from partial", 32'(pm), 0);
    chk("R4 driven after wake", 32'(den), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule